// File: doc/BRIEF.md
# Serial Control Register Port

This block is the write-only configuration slave of a multichannel audio converter. A host sends 16-bit command words over three wires: a serial clock, a data line and a latch strobe. Data is taken most significant bit first on each rising serial clock edge. When the latch line rises after exactly sixteen bits, the word is committed. The top four bits of the word name one of nine 10-bit registers. These are a format register, a mute register, a system register and six channel volume registers. The low ten bits become the new register contents. The fields of these registers drive the converter datapath directly, as decoded outputs. A latch strobe that follows any other number of bits throws the word away.

All three serial lines are sampled by the system clock `clk`, and edges are detected there. A four-state shifter tracks the bit count, and a register bank holds the settings. The shifter states and transitions are as follows:

- ST_EMPTY (no bits yet) moves to ST_LOAD on the first serial bit.
- ST_LOAD moves to ST_FULL on the sixteenth bit.
- ST_FULL moves to ST_OVER if a seventeenth bit arrives.
- A latch rise returns any state to ST_EMPTY. The latch rise commits the word only when it leaves ST_FULL.

The power-down control bit is deferred. The output follows it only on the commit after the one that captured it, so the host writes the command twice.

Top module: `ctlport_top`

## Requirements
- R1: Serial bits are shifted in on rising `ctl_sclk` edges, most significant bit first; bits 15..12 of the word form the register address and bits 9..0 its data; bits 11..10 are ignored.
- R2: Address 0 selects the format register, 1 the mute register, 2 through 7 the volumes of channels 1 through 6 (channel n appears on `vol_flat[10n-1:10n-10]`), and 8 the system register.
- R3: A committed word with address 9 through 15 leaves every register output unchanged.
- R4: A word is committed only when the latch rises after exactly 16 serial bits; a latch rise after 15 or 17 bits changes no output. Every latch rise clears the bit count, so the next word starts fresh.
- R5: After reset, volumes read all ones (0x3FF per channel) and every other output reads zero.
- R6: Format register fields: bits 9..8 to `deemph_sel`, bits 7..5 to `ser_fmt`, bits 4..3 to `word_len`, bits 1..0 to `interp_sel`.
- R7: Mute register bits 5..0 drive `mute_ch[5:0]`, with bit k muting channel k+1.
- R8: System register fields: bit 5 to `replicate`, bits 4..3 to `mclk_ratio`, bit 2 to `zero_pol`.
- R9: Each committed word, of any address, copies into `pwr_down` the format register bit 2 held before that commit, so a new power-down value appears only on the second commit.
- R10: Register outputs change exactly two `clk` cycles after the latch input rises (one sampling stage plus the register), and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial control clock |
| ctl_sdat | input | 1 | Serial control data |
| ctl_latch | input | 1 | Latch strobe; its rising edge ends a word |
| deemph_sel | output | 2 | De-emphasis curve select |
| ser_fmt | output | 3 | Audio serial format select |
| word_len | output | 2 | Audio word length select |
| interp_sel | output | 2 | Interpolation ratio select |
| pwr_down | output | 1 | Applied power-down state |
| mute_ch | output | 6 | Per-channel mute, bit k for channel k+1 |
| replicate | output | 1 | Channel 1 data copied to channels 2 and 3 |
| mclk_ratio | output | 2 | Master clock ratio select |
| zero_pol | output | 1 | Zero flag polarity |
| vol_flat | output | 60 | Six 10-bit channel volumes, channel 1 in the low bits |

## Verification
A corrupted bit count shows at the ports on the very next latch, in one of two ways: a valid word is dropped, or a short or long word lands in a register. A wrong address decode moves a value into the wrong output field within two cycles of the latch. A fault in the deferred power-down path shows on `pwr_down` one or two commits too early or too late. The bench keeps its own model of every register. It compares the model against all outputs on every clock, so a change that comes a cycle early or late is reported at once.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FULL  = 2'd2,
        ST_OVER  = 2'd3
    } shf_state_t;

    localparam int ADR_FMT      = 0;
    localparam int ADR_MUTE     = 1;
    localparam int ADR_VOL_BASE = 2;
    localparam int ADR_SYS      = 8;

endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic sdat_in,
    input  logic lat_in,
    output logic bit_stb,
    output logic bit_val,
    output logic lat_stb
);
    logic [2:0] now_q;
    logic [1:0] old_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            now_q <= '0;
            old_q <= '0;
        end else begin
            now_q <= {lat_in, sdat_in, sclk_in};
            old_q <= {now_q[2], now_q[0]};
        end
    end

    assign bit_stb = now_q[0] & ~old_q[0];
    assign bit_val = now_q[1];
    assign lat_stb = now_q[2] & ~old_q[1];

endmodule

// File: rtl/ctlport_shift.sv
module ctlport_shift
    import ctlport_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              lat_stb,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(WORD_W + 1);

    shf_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (lat_stb) state_nx = ST_EMPTY;
                      else if (bit_stb) state_nx = (WORD_W == 1) ? ST_FULL : ST_LOAD;
            ST_LOAD:  if (lat_stb) state_nx = ST_EMPTY;
                      else if (bit_stb && cnt == CNT_FULL - 1'b1) state_nx = ST_FULL;
            ST_FULL:  if (lat_stb) state_nx = ST_EMPTY;
                      else if (bit_stb) state_nx = ST_OVER;
            ST_OVER:  if (lat_stb) state_nx = ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        word_vld = lat_stb && (state == ST_FULL);
        word     = sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (lat_stb) begin
            cnt <= '0;
        end else if (bit_stb) begin
            sh <= {sh[WORD_W-2:0], bit_val};
            if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
        end
    end

    p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (cnt == CNT_FULL));
    p_load_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (cnt != '0 && cnt < CNT_FULL));
    p_clear_on_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lat_stb |=> (cnt == '0 && state == ST_EMPTY));
    p_cnt_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_TOP);

endmodule

// File: rtl/ctlport_regs.sv
module ctlport_regs
    import ctlport_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 10,
    parameter int NUM_VOL = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [WORD_W-1:0]         word,
    output logic [1:0]                deemph_sel,
    output logic [2:0]                ser_fmt,
    output logic [1:0]                word_len,
    output logic [1:0]                interp_sel,
    output logic                      pwr_down,
    output logic [NUM_VOL-1:0]        mute_ch,
    output logic                      replicate,
    output logic [1:0]                mclk_ratio,
    output logic                      zero_pol,
    output logic [NUM_VOL*DATA_W-1:0] vol_flat
);
    localparam int RSV_W = WORD_W - ADDR_W - DATA_W;

    logic [ADDR_W-1:0] adr;
    logic [DATA_W-1:0] dat;
    logic [DATA_W-1:0] fmt_r, mute_r, sys_r;
    logic              pd_act;

    assign adr = word[WORD_W-1 -: ADDR_W];
    assign dat = word[DATA_W-1:0];

    logic unused_bits;
    assign unused_bits = ^{word[DATA_W +: RSV_W], mute_r[DATA_W-1:NUM_VOL],
                           sys_r[DATA_W-1:6], sys_r[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_r  <= '0;
            mute_r <= '0;
            sys_r  <= '0;
            pd_act <= 1'b0;
        end else if (commit) begin
            pd_act <= fmt_r[2];
            if (adr == ADDR_W'(ADR_FMT))  fmt_r  <= dat;
            if (adr == ADDR_W'(ADR_MUTE)) mute_r <= dat;
            if (adr == ADDR_W'(ADR_SYS))  sys_r  <= dat;
        end
    end

    for (genvar g = 0; g < NUM_VOL; g++) begin : g_vol
        logic [DATA_W-1:0] vol_r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vol_r <= '1;
            else if (commit && adr == ADDR_W'(ADR_VOL_BASE + g))
                vol_r <= dat;
        end
        assign vol_flat[g*DATA_W +: DATA_W] = vol_r;
    end

    assign deemph_sel = fmt_r[9:8];
    assign ser_fmt    = fmt_r[7:5];
    assign word_len   = fmt_r[4:3];
    assign interp_sel = fmt_r[1:0];
    assign pwr_down   = pd_act;
    assign mute_ch    = mute_r[NUM_VOL-1:0];
    assign replicate  = sys_r[5];
    assign mclk_ratio = sys_r[4:3];
    assign zero_pol   = sys_r[2];

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({fmt_r, mute_r, sys_r, pd_act, vol_flat}));
    p_pd_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_act) |-> $past(commit));
    p_pd_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_act) |-> (pd_act == $past(fmt_r[2])));
    p_vol_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&vol_flat));

endmodule

// File: rtl/ctlport_top.sv
module ctlport_top #(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 10,
    parameter int NUM_VOL = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_sclk,
    input  logic                      ctl_sdat,
    input  logic                      ctl_latch,
    output logic [1:0]                deemph_sel,
    output logic [2:0]                ser_fmt,
    output logic [1:0]                word_len,
    output logic [1:0]                interp_sel,
    output logic                      pwr_down,
    output logic [NUM_VOL-1:0]        mute_ch,
    output logic                      replicate,
    output logic [1:0]                mclk_ratio,
    output logic                      zero_pol,
    output logic [NUM_VOL*DATA_W-1:0] vol_flat
);
    logic              bit_stb, bit_val, lat_stb, word_vld;
    logic [WORD_W-1:0] word;

    ctlport_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_in (ctl_sclk),
        .sdat_in (ctl_sdat),
        .lat_in  (ctl_latch),
        .bit_stb (bit_stb),
        .bit_val (bit_val),
        .lat_stb (lat_stb)
    );

    ctlport_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .bit_val  (bit_val),
        .lat_stb  (lat_stb),
        .word_vld (word_vld),
        .word     (word)
    );

    ctlport_regs #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_VOL(NUM_VOL)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (word_vld),
        .word       (word),
        .deemph_sel (deemph_sel),
        .ser_fmt    (ser_fmt),
        .word_len   (word_len),
        .interp_sel (interp_sel),
        .pwr_down   (pwr_down),
        .mute_ch    (mute_ch),
        .replicate  (replicate),
        .mclk_ratio (mclk_ratio),
        .zero_pol   (zero_pol),
        .vol_flat   (vol_flat)
    );

endmodule

// File: tb/ctlport_top_bench.sv
module ctlport_top_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_sclk = 1'b0, ctl_sdat = 1'b0, ctl_latch = 1'b0;
    logic [1:0] deemph_sel, word_len, interp_sel, mclk_ratio;
    logic [2:0] ser_fmt;
    logic       pwr_down, replicate, zero_pol;
    logic [5:0] mute_ch;
    logic [59:0] vol_flat;

    int total = 0;
    int bad = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    logic [9:0] m_c1 = '0, m_c2 = '0, m_c3 = '0;
    logic [9:0] m_vol [6];
    logic       m_pd = 1'b0;

    always #10 clk = ~clk;

    ctlport_top u_ctlport_top (
        .clk(clk), .rst_n(rst_n), .ctl_sclk(ctl_sclk), .ctl_sdat(ctl_sdat),
        .ctl_latch(ctl_latch), .deemph_sel(deemph_sel), .ser_fmt(ser_fmt),
        .word_len(word_len), .interp_sel(interp_sel), .pwr_down(pwr_down),
        .mute_ch(mute_ch), .replicate(replicate), .mclk_ratio(mclk_ratio),
        .zero_pol(zero_pol), .vol_flat(vol_flat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model compared on every clock: an early or late update is caught (R10).
    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            chk("R6/R10 deemph", 64'(deemph_sel), 64'(m_c1[9:8]));
            chk("R6/R10 fmt",    64'(ser_fmt),    64'(m_c1[7:5]));
            chk("R6/R10 width",  64'(word_len),   64'(m_c1[4:3]));
            chk("R6/R10 interp", 64'(interp_sel), 64'(m_c1[1:0]));
            chk("R9/R10 pd",     64'(pwr_down),   64'(m_pd));
            chk("R7/R10 mute",   64'(mute_ch),    64'(m_c2[5:0]));
            chk("R8/R10 rep",    64'(replicate),  64'(m_c3[5]));
            chk("R8/R10 mclk",   64'(mclk_ratio), 64'(m_c3[4:3]));
            chk("R8/R10 zpol",   64'(zero_pol),   64'(m_c3[2]));
            for (int c = 0; c < 6; c++)
                chk("R2/R10 vol", 64'(vol_flat[c*10 +: 10]), 64'(m_vol[c]));
        end
    end

    task automatic send(input logic [15:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ctl_sclk = 1'b0;
            ctl_sdat = (i < 16) ? w[15-i] : 1'b0;
            repeat (2) @(negedge clk);
            ctl_sclk = 1'b1;
            repeat (2) @(negedge clk);
        end
        ctl_sclk = 1'b0;
        repeat (2) @(negedge clk);
        ctl_latch = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        if (nbits == 16) begin
            m_pd = m_c1[2];
            case (w[15:12])
                4'd0: m_c1 = w[9:0];
                4'd1: m_c2 = w[9:0];
                4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: m_vol[w[15:12] - 4'd2] = w[9:0];
                4'd8: m_c3 = w[9:0];
                default: ;
            endcase
        end
        repeat (3) @(negedge clk);
        ctl_latch = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 6; c++) m_vol[c] = 10'h3FF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5 vol", 64'(vol_flat), {4'h0, {60{1'b1}}});
        chk("R5 fmt", 64'({deemph_sel, ser_fmt, word_len, interp_sel, pwr_down}), 64'd0);
        chk("R5 sys", 64'({mute_ch, replicate, mclk_ratio, zero_pol}), 64'd0);
        run_cmp = 1'b1;

        // R6 fields, pd=1 captured but not applied (R9)
        send({4'h0, 2'b11, 10'b10_101_01_1_10}, 16);
        chk("R6 deemph", 64'(deemph_sel), 64'd2);
        chk("R6 fmt",    64'(ser_fmt),    64'd5);
        chk("R6 width",  64'(word_len),   64'd1);
        chk("R6 interp", 64'(interp_sel), 64'd2);
        chk("R9 first write", 64'(pwr_down), 64'd0);

        // R7 mutes; this commit applies pd (R9)
        send({4'h1, 2'b00, 10'b0000_100101}, 16);
        chk("R7 mute", 64'(mute_ch), 64'h25);
        chk("R9 second commit", 64'(pwr_down), 64'd1);

        // R1/R2 bit order and volume addressing
        send({4'h2, 2'b00, 10'h2A5}, 16);
        send({4'h7, 2'b00, 10'h155}, 16);
        chk("R1 vol ch1", 64'(vol_flat[9:0]), 64'h2A5);
        chk("R2 vol ch6", 64'(vol_flat[59:50]), 64'h155);
        chk("R2 vol ch3", 64'(vol_flat[29:20]), 64'h3FF);

        // R8 system register
        send({4'h8, 2'b00, 10'h034}, 16);
        chk("R8 rep",  64'(replicate),  64'd1);
        chk("R8 mclk", 64'(mclk_ratio), 64'd2);
        chk("R8 zpol", 64'(zero_pol),   64'd1);

        // R3 reserved addresses
        send({4'h9, 2'b00, 10'h3FF}, 16);
        send({4'hF, 2'b00, 10'h000}, 16);
        chk("R3 vol", 64'(vol_flat[9:0]), 64'h2A5);
        chk("R3 mute", 64'(mute_ch), 64'h25);

        // R4 short and long words discarded, next word accepted
        send({4'h3, 2'b00, 10'h000}, 15);
        chk("R4 short", 64'(vol_flat[19:10]), 64'h3FF);
        send({4'h3, 2'b00, 10'h000}, 17);
        chk("R4 long", 64'(vol_flat[19:10]), 64'h3FF);
        send({4'h3, 2'b00, 10'h0C3}, 16);
        chk("R4 recovery", 64'(vol_flat[19:10]), 64'h0C3);

        // R9 release needs two writes
        send({4'h0, 2'b00, 10'h000}, 16);
        chk("R9 release pending", 64'(pwr_down), 64'd1);
        send({4'h0, 2'b00, 10'h000}, 16);
        chk("R9 release applied", 64'(pwr_down), 64'd0);

        // Mixed random traffic against the model
        for (int k = 0; k < 30; k++) begin
            logic [15:0] w;
            int nb;
            w  = 16'($urandom);
            nb = 15 + int'($urandom_range(0, 2));
            if (k % 3 == 0) nb = 16;
            send(w, nb);
        end

        repeat (5) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule